// File: doc/BRIEF.md
# MDIO Management Master

This block runs clause-22 management transactions to an external PHY over a two-wire management bus (a clock output and a bidirectional data line). Software sees four word registers. The first holds a PHY address, a register number and a read/write flag. The second holds the 16-bit value for a write. The third returns the 16-bit value captured by a read. The fourth holds an interface enable and a status bit.

To run a transaction, software first sets the enable. It then writes the control register with the status bit set. The block shifts out a 64-bit frame and releases the data line for the reply phase of a read. When the frame is done, the block clears the status bit. Software polls that bit until it reads zero.

The management clock is derived from the system clock by a half-period divider. The default of 20 cycles gives 2.5 MHz from a 100 MHz system clock.

Top module: `mdio_master`

## Requirements
- R1: After reset, all four registers read zero, `mdc` is low, `mdio_oe` is low and `mdio_o` is low.
- R2: Register byte offsets are fixed:
  - 0x7E4 (address register) reads back bits 10:0, where 4:0 is the register number, 9:5 is the PHY address and bit 10 is 1 for read, 0 for write.
  - 0x7E8 (write data) reads back bits 15:0.
  - 0x7EC (read data) is read-only and ignores writes.
  - 0x7F0 (control) has bit 3 as enable and bit 0 as status.
  - All other bits and all other offsets read zero.
- R3: A control write with bits 0 and 3 both set, while the block is idle, starts a transaction. Status then reads 1 until the block clears it, exactly 128·HALF_PERIOD cycles after the starting write.
- R4: A start request is ignored in two cases: when bit 3 of the written control value is 0, or when a transaction is already running. The running frame continues unchanged.
- R5: `mdc` is low while idle. During a transaction it toggles every HALF_PERIOD cycles, first rising HALF_PERIOD cycles after the start. It ends low.
- R6: The first 46 frame bits are sent MSB first: 32 ones, then 01, then the opcode (10 for read, 01 for write), then 5 PHY address bits, then 5 register bits. The first bit is driven from the cycle after the start. `mdio_o` changes only while `mdc` is low.
- R7: On a write, bits 46 to 63 are the turnaround 10 followed by the 16 data bits, MSB first. `mdio_oe` stays high for all 64 bits.
- R8: On a read, `mdio_oe` is low for bits 46 to 63. The 16 data bits are sampled from `mdio_i` on the rising `mdc` edges of bits 48 to 63, MSB first. The read-data register holds them after completion.
- R9: Frame fields are taken from the registers at the start. Register writes during a transaction do not alter the frame.
- R10: A write transaction leaves the read-data register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The assertions assume that `reg_wr` is a single-cycle strobe and that only one register is written per cycle. They also assume `mdio_i` is stable around each rising `mdc` edge. The stimulus applies every write for exactly one clock, with inputs changed on the falling system-clock edge. The bench's PHY responder updates `mdio_i` only in the half-period after `mdc` falls. That keeps every sample point at least HALF_PERIOD cycles clear of a data change.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int HALF_PERIOD = 20,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] OFF_ADDR = 12'h7E4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam logic [ADDR_W-1:0] OFF_WDAT = OFF_ADDR + ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_RDAT = OFF_ADDR + ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFF_CTRL = OFF_ADDR + ADDR_W'(12);
  localparam int CNT_W = $clog2(HALF_PERIOD + 1);
  localparam logic [CNT_W-1:0] DIV_TOP = CNT_W'(HALF_PERIOD - 1);

  logic [10:0] addr_q;
  logic [15:0] wdat_q, rdat_q;
  logic        en_q, busy_q, mdc_q, op_rd_q;
  logic [63:0] sh_q;
  logic [5:0]  bit_q;
  logic [CNT_W-1:0] div_q;

  wire hit_ctrl   = reg_wr && (reg_addr == OFF_CTRL);
  wire start      = hit_ctrl && reg_wdata[0] && reg_wdata[3] && !busy_q;
  wire tick       = busy_q && (div_q == DIV_TOP);
  wire in_reply   = op_rd_q && (bit_q >= 6'd46);

  assign mdc     = mdc_q;
  assign mdio_oe = busy_q && !in_reply;
  assign mdio_o  = mdio_oe && sh_q[63];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0; wdat_q <= '0; rdat_q <= '0;
      en_q <= 1'b0; busy_q <= 1'b0; mdc_q <= 1'b0; op_rd_q <= 1'b0;
      sh_q <= '0; bit_q <= '0; div_q <= '0;
    end else begin
      if (reg_wr && reg_addr == OFF_ADDR) addr_q <= reg_wdata[10:0];
      if (reg_wr && reg_addr == OFF_WDAT) wdat_q <= reg_wdata[15:0];
      if (hit_ctrl) en_q <= reg_wdata[3];
      if (start) begin
        busy_q  <= 1'b1;
        op_rd_q <= addr_q[10];
        div_q   <= '0;
        bit_q   <= '0;
        mdc_q   <= 1'b0;
        sh_q    <= {32'hFFFF_FFFF, 2'b01, (addr_q[10] ? 2'b10 : 2'b01),
                    addr_q[9:5], addr_q[4:0],
                    (addr_q[10] ? 18'h0 : {2'b10, wdat_q})};
      end else if (busy_q) begin
        if (tick) begin
          div_q <= '0;
          mdc_q <= ~mdc_q;
          if (!mdc_q) begin
            if (in_reply && bit_q >= 6'd48) rdat_q <= {rdat_q[14:0], mdio_i};
          end else if (bit_q == 6'd63) begin
            busy_q <= 1'b0;
          end else begin
            bit_q <= bit_q + 6'd1;
            sh_q  <= {sh_q[62:0], 1'b0};
          end
        end else begin
          div_q <= div_q + CNT_W'(1);
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFF_ADDR) reg_rdata = {21'h0, addr_q};
    else if (reg_addr == OFF_WDAT) reg_rdata = {16'h0, wdat_q};
    else if (reg_addr == OFF_RDAT) reg_rdata = {16'h0, rdat_q};
    else if (reg_addr == OFF_CTRL) reg_rdata = {28'h0, en_q, 2'b00, busy_q};
  end

  a_r3_frame_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(bit_q) == 6'd63);
  a_r4_disabled_start: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_ctrl && !reg_wdata[3] && !busy_q) |=> !busy_q);
  a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && hit_ctrl && bit_q != 6'd63) |=> (busy_q && bit_q >= $past(bit_q)));
  a_r5_end_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> !mdc_q);
  a_r6_change_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mdio_o) && busy_q) |-> !mdc_q);
  a_r10_rdata_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !op_rd_q) |=> $stable(rdat_q));
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  localparam int HALF = 20;
  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, mdio_i = 1'b1;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mdc, mdio_o, mdio_oe;
  int nchk = 0, nfail = 0;

  mdio_master u_dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #5 clk = ~clk;

  // reference model
  bit fr[$];
  int m_t = 0, m_bit = 0, m_n = 0;
  bit m_busy = 0, m_rd = 0;
  logic [10:0] m_addr = '0;
  logic [15:0] m_wdat = '0;
  logic [15:0] phy_val = '0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) if (rst_n) begin
    if (m_busy) begin
      m_t++;
      m_n = m_t / HALF;
      if (m_n >= 128) m_busy = 0;
      else m_bit = m_n >> 1;
    end else if (reg_wr && reg_addr == 12'h7F0 && reg_wdata[0] && reg_wdata[3]) begin
      m_busy = 1; m_t = 0; m_n = 0; m_bit = 0; m_rd = m_addr[10];
      fr.delete();
      for (int i = 0; i < 32; i++) fr.push_back(1'b1);
      fr.push_back(1'b0); fr.push_back(1'b1);
      fr.push_back(m_rd ? 1'b1 : 1'b0); fr.push_back(m_rd ? 1'b0 : 1'b1);
      for (int i = 9; i >= 0; i--) fr.push_back(m_addr[i]);
      fr.push_back(1'b1); fr.push_back(1'b0);
      for (int i = 15; i >= 0; i--) fr.push_back(m_rd ? 1'b0 : m_wdat[i]);
    end
    if (reg_wr && reg_addr == 12'h7E4) m_addr = reg_wdata[10:0];
    if (reg_wr && reg_addr == 12'h7E8) m_wdat = reg_wdata[15:0];
  end

  always @(negedge clk) if (rst_n) begin
    bit eoe, emdc, eo;
    string tag;
    emdc = m_busy ? m_n[0] : 1'b0;
    eoe  = m_busy && !(m_rd && m_bit >= 46);
    eo   = eoe ? fr[m_bit] : 1'b0;
    tag  = (m_bit < 46 || !m_busy) ? "R6" : (m_rd ? "R8" : "R7");
    check(mdc === emdc, "R5", mdc, emdc);
    check(mdio_oe === eoe, tag, mdio_oe, eoe);
    check(mdio_o === eo, tag, mdio_o, eo);
    mdio_i <= (m_busy && m_rd && m_bit >= 48) ? phy_val[63 - m_bit] : 1'b1;
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); reg_addr = a; #1;
    check(reg_rdata === exp, req, reg_rdata, exp);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk(12'h7E4, 0, "R1"); rd_chk(12'h7E8, 0, "R1");
    rd_chk(12'h7EC, 0, "R1"); rd_chk(12'h7F0, 0, "R1");
    check(mdc === 1'b0 && mdio_oe === 1'b0 && mdio_o === 1'b0, "R1", {mdc, mdio_oe, mdio_o}, 0);
    // R2 register map
    wr(12'h7E4, 32'hFFFF_FFFF); rd_chk(12'h7E4, 32'h7FF, "R2");
    wr(12'h7E8, 32'hFFFF_ABCD); rd_chk(12'h7E8, 32'hABCD, "R2");
    wr(12'h7EC, 32'h0000_DEAD); rd_chk(12'h7EC, 0, "R2");
    rd_chk(12'h7F4, 0, "R2");
    // R4 start with enable clear is ignored
    wr(12'h7F0, 32'h1);
    repeat (50) @(negedge clk);
    rd_chk(12'h7F0, 0, "R4");
    wr(12'h7F0, 32'h8); rd_chk(12'h7F0, 32'h8, "R2");
    // R7 write transaction, with R9/R4 disturbances mid-frame
    wr(12'h7E4, 32'h0A3); wr(12'h7E8, 32'hA5C3);
    wr(12'h7F0, 32'h9);
    rd_chk(12'h7F0, 32'h9, "R3");
    repeat (1000) @(negedge clk);
    wr(12'h7E4, 32'h7FF); wr(12'h7E8, 32'h0F0F);
    wr(12'h7F0, 32'h9);
    rd_chk(12'h7F0, 32'h9, "R4");
    wait_idle();
    rd_chk(12'h7F0, 32'h8, "R3");
    rd_chk(12'h7EC, 0, "R10");
    // R8 read transactions
    phy_val = 16'h1234;
    wr(12'h7E4, 32'h7E0); wr(12'h7F0, 32'h9);
    wait_idle();
    rd_chk(12'h7EC, 32'h1234, "R8");
    rd_chk(12'h7F0, 32'h8, "R3");
    phy_val = 16'h8001;
    wr(12'h7E4, 32'h41F); wr(12'h7F0, 32'h9);
    wait_idle();
    rd_chk(12'h7EC, 32'h8001, "R8");
    // R10 write after read keeps captured value
    wr(12'h7E4, 32'h021); wr(12'h7E8, 32'h5A5A); wr(12'h7F0, 32'h9);
    wait_idle();
    rd_chk(12'h7EC, 32'h8001, "R10");
    finish_run();
  end
endmodule